// File: doc/BRIEF.md
# Three-Operand Execute and Branch Unit

This block is the execute stage of a small register-register core. Each cycle it may accept one decoded operation with its opcode, a destination index, three register operand values (`ra`, `rb`, `rc`) and an immediate. One clock edge later it presents registered results. These take one of three forms:

- a register write-back (enable, index, value);
- a branch decision with its target address;
- a memory request with address, write data and a read/write flag.

Arithmetic and logic operations take `rb` and `rc` as sources and write to the register named by the destination index. Shifts take their signed distance from `rc`. Every conditional branch compares `rb` against `rc` as signed values and jumps to the address held in `ra`. Loads and stores only drive the memory request, because the data transfer itself lives outside this unit. A sticky flag records any division by zero until reset.

Top module: `rrx_exec_unit`

## Requirements
- R1: With `in_valid` high, opcodes MOV=0x01, MOVI=0x02, ADD=0x03, SUB=0x04, MUL=0x05, AND=0x07, OR=0x08 and NOT=0x09 produce, one cycle later, `out_wr_en`=1, `out_dst`=`ra_idx` and `out_result` equal to:
  - `rb` for MOV;
  - `imm` for MOVI;
  - `rb` op `rc` for ADD, SUB, AND and OR;
  - the low 32 bits of `rb*rc` for MUL;
  - `~rb` for NOT.
- R2: DIV=0x06 writes the signed quotient `rb/rc`, truncated toward zero. The case 0x80000000 / -1 yields 0x80000000.
- R3: DIV with `rc`=0 writes 0xFFFFFFFF and sets `div_err`. `div_err` stays set until reset.
- R4: LSH=0x0B treats `rc` as a signed count. A positive count shifts `rb` left and a negative count shifts it right, filling with zeros. A count magnitude of 32 or more gives 0.
- R5: ASH=0x0A shifts left for a positive `rc` and right with sign fill for a negative `rc`. A magnitude of 32 or more gives 0 when shifting left and all copies of `rb`'s sign bit when shifting right.
- R6: BR=0x0C gives `out_br_taken`=1 with `out_br_target`=`ra`. BRI=0x0D gives `out_br_taken`=1 with target `imm`.
- R7: BEQ=0x0E, BNE=0x0F, BLT=0x10, BGT=0x11, BLE=0x12 and BGE=0x13 compare `rb` with `rc` as signed values. When the condition holds they set `out_br_taken` with target `ra`; otherwise `out_br_taken`=0. None of them writes a register.
- R8: LD=0x14 gives `out_mem_req`=1, `out_mem_we`=0 and `out_mem_addr`=`rb`. ST=0x15 gives `out_mem_req`=1, `out_mem_we`=1, `out_mem_addr`=`ra` and `out_mem_wdata`=`rb`. Neither sets `out_wr_en`.
- R9: When `in_valid` is low, or the opcode is NOP=0x00 or any code above 0x15, the next cycle has `out_wr_en`, `out_br_taken` and `out_mem_req` all 0. At most one of these three is ever high.
- R10: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Decoded opcode |
| ra_idx | input | 5 | Destination register index |
| ra_val | input | 32 | Value of register ra |
| rb_val | input | 32 | Value of register rb |
| rc_val | input | 32 | Value of register rc |
| imm_val | input | 32 | Immediate constant |
| out_wr_en | output | 1 | Register write-back enable |
| out_dst | output | 5 | Write-back register index |
| out_result | output | 32 | Write-back value |
| out_br_taken | output | 1 | Branch taken |
| out_br_target | output | 32 | Branch target address |
| out_mem_req | output | 1 | Memory access request |
| out_mem_we | output | 1 | Memory access is a write |
| out_mem_addr | output | 32 | Memory address |
| out_mem_wdata | output | 32 | Memory write data |
| div_err | output | 1 | Sticky division-by-zero flag |

## Verification
The bench targets the edges of the signed shift count:
- a count of exactly 32 and of -32;
- a right shift by 31;
- arithmetic right shifts of both a negative and a positive value past the width.

A design that ignored the sign of `rc`, or wrapped the count modulo 32, would return the unshifted value or shift the wrong way.

The branch tests use operands of opposite sign, so an unsigned comparison would take BLT and BGT the wrong way.

For division, the bench checks:
- a negative dividend, which catches a design that floors instead of truncating;
- the overflowing quotient;
- division by zero, followed by further operations that show whether the error flag stays set.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 5'h00, OP_MOV  = 5'h01, OP_MOVI = 5'h02, OP_ADD = 5'h03,
    OP_SUB  = 5'h04, OP_MUL  = 5'h05, OP_DIV  = 5'h06, OP_AND = 5'h07,
    OP_OR   = 5'h08, OP_NOT  = 5'h09, OP_ASH  = 5'h0A, OP_LSH = 5'h0B,
    OP_BR   = 5'h0C, OP_BRI  = 5'h0D, OP_BEQ  = 5'h0E, OP_BNE = 5'h0F,
    OP_BLT  = 5'h10, OP_BGT  = 5'h11, OP_BLE  = 5'h12, OP_BGE = 5'h13,
    OP_LD   = 5'h14, OP_ST   = 5'h15
  } rrx_op_e;
endpackage

// File: rtl/rrx_alu.sv
module rrx_alu
  import rrx_pkg::*;
#(
  parameter int W = 32
) (
  input  rrx_op_e        op,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  input  logic [W-1:0]   imm,
  output logic [W-1:0]   res,
  output logic           div_zero
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] quot;

  always_comb begin
    if (c == '0)                   quot = '1;
    else if (b == MIN_NEG && c == '1) quot = MIN_NEG;
    else                           quot = W'($signed(b) / $signed(c));
  end

  always_comb begin
    div_zero = 1'b0;
    case (op)
      OP_MOV:  res = b;
      OP_MOVI: res = imm;
      OP_ADD:  res = b + c;
      OP_SUB:  res = b - c;
      OP_MUL:  res = b * c;
      OP_DIV:  begin res = quot; div_zero = (c == '0); end
      OP_AND:  res = b & c;
      OP_OR:   res = b | c;
      OP_NOT:  res = ~b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rrx_shifter.sv
module rrx_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         arith,
  output logic [W-1:0] res
);
  localparam int SW = $clog2(W);

  logic         neg;
  logic [W:0]   mag;
  logic         big;
  logic [SW-1:0] amt;
  logic [W-1:0] sh_l, sh_rl, sh_ra;

  always_comb begin
    neg   = c[W-1];
    mag   = neg ? ({1'b0, ~c} + (W+1)'(1)) : {1'b0, c};
    big   = (mag >= (W+1)'(W));
    amt   = mag[SW-1:0];
    sh_l  = b << amt;
    sh_rl = b >> amt;
    sh_ra = W'($signed(b) >>> amt);
    if (!neg)      res = big ? '0 : sh_l;
    else if (arith) res = big ? {W{b[W-1]}} : sh_ra;
    else           res = big ? '0 : sh_rl;
  end
endmodule

// File: rtl/rrx_brcmp.sv
module rrx_brcmp
  import rrx_pkg::*;
#(
  parameter int W = 32
) (
  input  rrx_op_e      op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         hit
);
  logic eq, lt;

  always_comb begin
    eq = (b == c);
    lt = ($signed(b) < $signed(c));
    case (op)
      OP_BEQ:  hit = eq;
      OP_BNE:  hit = !eq;
      OP_BLT:  hit = lt;
      OP_BGT:  hit = !lt && !eq;
      OP_BLE:  hit = lt || eq;
      OP_BGE:  hit = !lt;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rrx_exec_unit.sv
module rrx_exec_unit
  import rrx_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    op_code,
  input  logic [AW-1:0] ra_idx,
  input  logic [W-1:0]  ra_val,
  input  logic [W-1:0]  rb_val,
  input  logic [W-1:0]  rc_val,
  input  logic [W-1:0]  imm_val,
  output logic          out_wr_en,
  output logic [AW-1:0] out_dst,
  output logic [W-1:0]  out_result,
  output logic          out_br_taken,
  output logic [W-1:0]  out_br_target,
  output logic          out_mem_req,
  output logic          out_mem_we,
  output logic [W-1:0]  out_mem_addr,
  output logic [W-1:0]  out_mem_wdata,
  output logic          div_err
);
  rrx_op_e      op;
  logic [W-1:0] alu_res, sh_res;
  logic         alu_dz, cmp_hit;

  assign op = rrx_op_e'(op_code);

  rrx_alu #(.W(W)) u_alu (
    .op(op), .b(rb_val), .c(rc_val), .imm(imm_val), .res(alu_res), .div_zero(alu_dz)
  );

  rrx_shifter #(.W(W)) u_shift (
    .b(rb_val), .c(rc_val), .arith(op == OP_ASH), .res(sh_res)
  );

  rrx_brcmp #(.W(W)) u_cmp (
    .op(op), .b(rb_val), .c(rc_val), .hit(cmp_hit)
  );

  logic         n_wr, n_br, n_mem, n_we, n_dz;
  logic [W-1:0] n_res, n_tgt, n_addr, n_wdata;

  always_comb begin
    n_wr = 1'b0; n_br = 1'b0; n_mem = 1'b0; n_we = 1'b0; n_dz = 1'b0;
    n_res = alu_res; n_tgt = ra_val; n_addr = rb_val; n_wdata = rb_val;
    if (in_valid) begin
      case (op)
        OP_MOV, OP_MOVI, OP_ADD, OP_SUB, OP_MUL,
        OP_DIV, OP_AND, OP_OR, OP_NOT: begin
          n_wr = 1'b1;
          n_dz = alu_dz;
        end
        OP_ASH, OP_LSH: begin
          n_wr  = 1'b1;
          n_res = sh_res;
        end
        OP_BR:  n_br = 1'b1;
        OP_BRI: begin n_br = 1'b1; n_tgt = imm_val; end
        OP_BEQ, OP_BNE, OP_BLT, OP_BGT, OP_BLE, OP_BGE: n_br = cmp_hit;
        OP_LD:  n_mem = 1'b1;
        OP_ST:  begin n_mem = 1'b1; n_we = 1'b1; n_addr = ra_val; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr_en <= 1'b0; out_dst <= '0; out_result <= '0;
      out_br_taken <= 1'b0; out_br_target <= '0;
      out_mem_req <= 1'b0; out_mem_we <= 1'b0;
      out_mem_addr <= '0; out_mem_wdata <= '0; div_err <= 1'b0;
    end else begin
      out_wr_en     <= n_wr;
      out_dst       <= ra_idx;
      out_result    <= n_res;
      out_br_taken  <= n_br;
      out_br_target <= n_tgt;
      out_mem_req   <= n_mem;
      out_mem_we    <= n_we;
      out_mem_addr  <= n_addr;
      out_mem_wdata <= n_wdata;
      div_err       <= div_err | n_dz;
    end
  end

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err);

  a_r3_div_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_DIV && rc_val == '0) |=> (out_result == '1 && div_err && out_wr_en));

  a_r6_br_uncond: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_BR) |=> (out_br_taken && out_br_target == $past(ra_val)));

  a_r8_store_req: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_ST) |=> (out_mem_req && out_mem_we && out_mem_addr == $past(ra_val)));

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_wr_en && !out_br_taken && !out_mem_req));

  a_r9_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_wr_en, out_br_taken, out_mem_req}));
endmodule

// File: tb/rrx_exec_unit_test.sv
module rrx_exec_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        wr;
    logic [4:0]  dst;
    logic [31:0] res;
    logic        br;
    logic [31:0] tgt;
    logic        mem;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        err;
  } exp_t;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [4:0]  op_code = 0, ra_idx = 0;
  logic [31:0] ra_val = 0, rb_val = 0, rc_val = 0, imm_val = 0;
  logic out_wr_en, out_br_taken, out_mem_req, out_mem_we, div_err;
  logic [4:0]  out_dst;
  logic [31:0] out_result, out_br_target, out_mem_addr, out_mem_wdata;

  int tests = 0, fails = 0;
  logic exp_err = 0;
  exp_t  q[$];
  string tq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rrx_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .ra_idx(ra_idx),
    .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val), .imm_val(imm_val),
    .out_wr_en(out_wr_en), .out_dst(out_dst), .out_result(out_result),
    .out_br_taken(out_br_taken), .out_br_target(out_br_target),
    .out_mem_req(out_mem_req), .out_mem_we(out_mem_we),
    .out_mem_addr(out_mem_addr), .out_mem_wdata(out_mem_wdata), .div_err(div_err)
  );

  function automatic exp_t e_none();
    exp_t e;
    e = '{default: '0};
    return e;
  endfunction
  function automatic exp_t e_wb(logic [4:0] d, logic [31:0] r);
    exp_t e = e_none();
    e.wr = 1; e.dst = d; e.res = r;
    return e;
  endfunction
  function automatic exp_t e_br(logic [31:0] t);
    exp_t e = e_none();
    e.br = 1; e.tgt = t;
    return e;
  endfunction
  function automatic exp_t e_mem(logic w, logic [31:0] a, logic [31:0] d);
    exp_t e = e_none();
    e.mem = 1; e.we = w; e.addr = a; e.wdata = d;
    return e;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(string tag, logic v, logic [4:0] op, logic [4:0] d,
                       logic [31:0] a, logic [31:0] b, logic [31:0] c,
                       logic [31:0] im, exp_t e);
    @(negedge clk);
    in_valid = v; op_code = op; ra_idx = d;
    ra_val = a; rb_val = b; rc_val = c; imm_val = im;
    if (v && op == 5'h06 && c == 0) exp_err = 1;
    e.err = exp_err;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t  e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      check(t, "wr_en", 32'(out_wr_en), 32'(e.wr));
      check(t, "br_taken", 32'(out_br_taken), 32'(e.br));
      check(t, "mem_req", 32'(out_mem_req), 32'(e.mem));
      check(t, "div_err", 32'(div_err), 32'(e.err));
      if (e.wr) begin
        check(t, "dst", 32'(out_dst), 32'(e.dst));
        check(t, "result", out_result, e.res);
      end
      if (e.br) check(t, "target", out_br_target, e.tgt);
      if (e.mem) begin
        check(t, "mem_we", 32'(out_mem_we), 32'(e.we));
        check(t, "mem_addr", out_mem_addr, e.addr);
        if (e.we) check(t, "mem_wdata", out_mem_wdata, e.wdata);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", "wr_en", 32'(out_wr_en), 0);
    check("R10", "br_taken", 32'(out_br_taken), 0);
    check("R10", "mem_req", 32'(out_mem_req), 0);
    check("R10", "result", out_result, 0);
    check("R10", "div_err", 32'(div_err), 0);
    rst = 0;

    // R1 register operations
    issue("R1", 1, 5'h03, 5'd4,  0, 5, 7, 0, e_wb(4, 12));
    issue("R1", 1, 5'h04, 5'd5,  0, 3, 10, 0, e_wb(5, 32'hFFFF_FFF9));
    issue("R1", 1, 5'h05, 5'd6,  0, 32'h0001_0000, 32'h0001_0003, 0, e_wb(6, 32'h0003_0000));
    issue("R1", 1, 5'h07, 5'd7,  0, 32'hF0F0_FF00, 32'h0FF0_F0F0, 0, e_wb(7, 32'h00F0_F000));
    issue("R1", 1, 5'h08, 5'd8,  0, 32'hF000_0001, 32'h0000_0F10, 0, e_wb(8, 32'hF000_0F11));
    issue("R1", 1, 5'h09, 5'd9,  0, 0, 0, 0, e_wb(9, 32'hFFFF_FFFF));
    issue("R1", 1, 5'h01, 5'd10, 0, 32'hCAFE_0001, 0, 0, e_wb(10, 32'hCAFE_0001));
    issue("R1", 1, 5'h02, 5'd31, 0, 1, 2, 32'h0000_1234, e_wb(31, 32'h0000_1234));
    // R2 signed division
    issue("R2", 1, 5'h06, 5'd1, 0, 32'hFFFF_FFF9, 2, 0, e_wb(1, 32'hFFFF_FFFD));
    issue("R2", 1, 5'h06, 5'd2, 0, 100, 7, 0, e_wb(2, 14));
    issue("R2", 1, 5'h06, 5'd3, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, e_wb(3, 32'h8000_0000));
    // R3 division by zero, then sticky
    issue("R3", 1, 5'h06, 5'd4, 0, 5, 0, 0, e_wb(4, 32'hFFFF_FFFF));
    issue("R3", 1, 5'h03, 5'd5, 0, 1, 1, 0, e_wb(5, 2));
    issue("R3", 0, 5'h00, 5'd0, 0, 0, 0, 0, e_none());
    // R4 logical shifts
    issue("R4", 1, 5'h0B, 5'd1, 0, 1, 4, 0, e_wb(1, 16));
    issue("R4", 1, 5'h0B, 5'd1, 0, 32'h80, 32'hFFFF_FFFC, 0, e_wb(1, 8));
    issue("R4", 1, 5'h0B, 5'd1, 0, 32'h8000_0000, 32'hFFFF_FFE1, 0, e_wb(1, 1));
    issue("R4", 1, 5'h0B, 5'd1, 0, 32'hFFFF_FFFF, 32, 0, e_wb(1, 0));
    issue("R4", 1, 5'h0B, 5'd1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFE0, 0, e_wb(1, 0));
    issue("R4", 1, 5'h0B, 5'd1, 0, 32'h8000_0000, 32'hFFFF_FFFC, 0, e_wb(1, 32'h0800_0000));
    // R5 arithmetic shifts
    issue("R5", 1, 5'h0A, 5'd2, 0, 32'h8000_0000, 32'hFFFF_FFFC, 0, e_wb(2, 32'hF800_0000));
    issue("R5", 1, 5'h0A, 5'd2, 0, 32'h8000_0000, 32'hFFFF_FFD8, 0, e_wb(2, 32'hFFFF_FFFF));
    issue("R5", 1, 5'h0A, 5'd2, 0, 32'h40, 32'hFFFF_FFD8, 0, e_wb(2, 0));
    issue("R5", 1, 5'h0A, 5'd2, 0, 3, 2, 0, e_wb(2, 12));
    issue("R5", 1, 5'h0A, 5'd2, 0, 1, 33, 0, e_wb(2, 0));
    // R6 unconditional branches
    issue("R6", 1, 5'h0C, 5'd0, 32'h0000_0100, 0, 0, 0, e_br(32'h0000_0100));
    issue("R6", 1, 5'h0D, 5'd0, 32'h0000_0100, 0, 0, 32'h44, e_br(32'h44));
    // R7 conditional branches
    issue("R7", 1, 5'h0E, 5'd0, 32'h200, 5, 5, 0, e_br(32'h200));
    issue("R7", 1, 5'h0F, 5'd0, 32'h200, 5, 5, 0, e_none());
    issue("R7", 1, 5'h10, 5'd0, 32'h300, 32'hFFFF_FFFF, 1, 0, e_br(32'h300));
    issue("R7", 1, 5'h11, 5'd0, 32'h300, 32'hFFFF_FFFF, 1, 0, e_none());
    issue("R7", 1, 5'h12, 5'd0, 32'h400, 4, 4, 0, e_br(32'h400));
    issue("R7", 1, 5'h13, 5'd0, 32'h400, 3, 4, 0, e_none());
    issue("R7", 1, 5'h13, 5'd0, 32'h500, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 0, e_br(32'h500));
    issue("R7", 1, 5'h11, 5'd0, 32'h600, 1, 32'h8000_0000, 0, e_br(32'h600));
    // R8 memory requests
    issue("R8", 1, 5'h14, 5'd3, 32'h11, 32'h0000_1000, 0, 0, e_mem(0, 32'h0000_1000, 0));
    issue("R8", 1, 5'h15, 5'd3, 32'h0000_2000, 32'hDEAD_BEEF, 0, 0, e_mem(1, 32'h0000_2000, 32'hDEAD_BEEF));
    // R9 idle, NOP and undefined opcodes
    issue("R9", 0, 5'h03, 5'd1, 0, 1, 1, 0, e_none());
    issue("R9", 1, 5'h00, 5'd1, 0, 1, 1, 0, e_none());
    issue("R9", 1, 5'h1F, 5'd1, 0, 1, 1, 0, e_none());
    issue("R9", 1, 5'h16, 5'd1, 0, 1, 1, 0, e_none());
    issue("R9", 0, 5'h00, 5'd0, 0, 0, 0, 0, e_none());

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule